// File: doc/BRIEF.md
# PCI Configuration Access Engine

This block sits between a local processor and a PCI host bridge. It turns one configuration-space request into bus cycles on a simple dword port. A request names a device number, a function, a register offset, an access size of 1, 2 or 4 bytes and a direction. The engine forms a configuration address whose device-select bit is one-hot. It always starts by fetching the whole dword. A read returns the selected bytes right-aligned. A write merges the new bytes into the fetched dword and writes the full dword back.

Around each access the engine raises a configuration-select level, so the shared window carries configuration cycles rather than memory cycles. It also pulses an abort-clear strobe so that a stale abort cannot be mistaken for a fresh one. Three kinds of request end with no bus traffic at all: an illegal size or alignment, a device outside the select range or address window, and an access to the bridge's own slot from the external path. A master abort during either phase ends the access as not-found.

Top module: `pci_cfg_engine`

## Requirements
- R1: On every bus cycle of an accepted request, bus_addr equals 2^(13+dev) OR (func shifted left by 8) OR (off with bits 1:0 forced to zero).
- R2: A request with a device number above 18, or whose formed address is 2^20 or more (device 7 and up), completes with done_status 01 (not found). It raises no bus_req, no abort_clr and no cfg_select. A read returns 0xFFFFFFFF and a write returns 0.
- R3: With req_local low, device 3 is refused as in R2. With req_local high, the same device is accessed normally.
- R4: A size other than 1, 2 or 4, or an off[1:0] + size above 4, completes with done_status 10 (invalid) and no bus cycle. This check is made before R2 and R3. A read returns 0xFFFFFFFF and a write returns 0.
- R5: Every request that passes R2 to R4 pulses abort_clr for one cycle, in the cycle after acceptance and before the first bus_req. cfg_select rises in that same cycle, stays high through the last bus cycle, and is low while done_valid is high.
- R6: A read issues exactly one bus read. It returns done_status 00 and done_rdata equal to the fetched dword shifted right by 8*off[1:0], with only the low size bytes kept.
- R7: A write issues one read and then one write to the same address. The written dword is the fetched dword with byte lanes off[1:0] through off[1:0]+size-1 replaced by the low size bytes of req_wdata. It returns done_status 00 and done_rdata 0.
- R8: If bus_abort is high with bus_ack in either phase, the next cycle pulses abort_clr and no further bus cycle follows. The request completes with done_status 01. A read returns 0xFFFFFFFF and a write returns 0.
- R9: req_ready is high only when the engine is idle. Each accepted request gives exactly one single-cycle done_valid. For a refused request it comes one cycle after the acceptance edge. Otherwise bus_req first appears two cycles after acceptance, and done_valid follows one cycle after the final ack, or two cycles after an aborted ack. bus_req, bus_addr, bus_write and bus_wdata hold steady until bus_ack.
- R10: While reset is held and just after its release: req_ready 1, done_valid 0, bus_req 0, cfg_select 0, abort_clr 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_local | input | 1 | Request comes from the internal setup path (own slot allowed) |
| req_dev | input | DEV_W | Device number |
| req_func | input | FUNC_W | Function number |
| req_off | input | OFF_W | Register byte offset |
| req_size | input | SIZE_W | Access size in bytes |
| req_wdata | input | DATA_W | Write data, right-aligned |
| done_valid | output | 1 | One-cycle completion strobe |
| done_status | output | 2 | 00 ok, 01 not found, 10 invalid |
| done_rdata | output | DATA_W | Read result |
| bus_req | output | 1 | Bus cycle request |
| bus_write | output | 1 | Bus cycle direction |
| bus_addr | output | ADDR_W | Configuration dword address |
| bus_wdata | output | DATA_W | Merged dword for the write phase |
| bus_ack | input | 1 | Bus cycle complete |
| bus_abort | input | 1 | Master abort, valid with bus_ack |
| bus_rdata | input | DATA_W | Fetched dword, valid with bus_ack |
| cfg_select | output | 1 | Window carries configuration cycles |
| abort_clr | output | 1 | Clear pending abort status |

## Verification
The hardest situation to reach is an abort that arrives in the write-back phase. The read phase must already have succeeded, and the abort must then stop the access with the target left unchanged. The bench's target model marks one device as answering reads but aborting writes, and another as absent, so that aborts in both phases occur. Bus latency is varied from zero wait cycles upward, which moves the completion cycle the bench predicts. The window edge is probed with device 6, the highest legal device, and device 7, the first one refused.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

   typedef enum logic [1:0] {
      CFG_OK        = 2'b00,
      CFG_NOT_FOUND = 2'b01,
      CFG_INVALID   = 2'b10
   } cfg_status_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PREP,
      SQ_READ,
      SQ_WRITE,
      SQ_ABORT,
      SQ_DONE
   } seq_state_e;

endpackage

// File: rtl/pci_cfg_decode.sv
// Address formation and request screening (combinational).
module pci_cfg_decode
   import pci_cfg_pkg::*;
#(
   parameter int DEV_W       = 5,
   parameter int FUNC_W      = 3,
   parameter int OFF_W       = 8,
   parameter int SIZE_W      = 3,
   parameter int ADDR_W      = 32,
   parameter int BYTES       = 4,
   parameter int IDSEL_BASE  = 13,
   parameter int FUNC_LSB    = 8,
   parameter int MAX_DEV     = 18,
   parameter int WIN_BITS    = 20,
   parameter int HOST_SLOT   = 3,
   parameter bit HOST_FILTER = 1'b1,
   localparam int SH_W       = $clog2(BYTES)
) (
   input  logic [DEV_W-1:0]  dev,
   input  logic [FUNC_W-1:0] func,
   input  logic [OFF_W-1:0]  off,
   input  logic [SIZE_W-1:0] size,
   input  logic              is_local,
   output logic [ADDR_W-1:0] addr,
   output cfg_status_e       status,
   output logic [BYTES-1:0]  lanes,
   output logic [SH_W-1:0]   shift
);

   localparam int ONEHOT_W = IDSEL_BASE + (1 << DEV_W);

   if (OFF_W > FUNC_LSB) begin : g_bad_off
      $error("offset field overlaps function field");
   end
   if (FUNC_LSB + FUNC_W > IDSEL_BASE) begin : g_bad_func
      $error("function field overlaps device select");
   end
   if (WIN_BITS > ADDR_W || ONEHOT_W < ADDR_W) begin : g_bad_win
      $error("address window does not fit the bus address");
   end

   logic [ONEHOT_W-1:0] sel_wide;
   logic [ONEHOT_W-1:0] full_addr;
   logic                out_of_window;
   logic                dev_high;
   logic                host_hit;
   logic                size_legal;
   logic                crosses;
   logic [BYTES:0]      base_wide;

   assign sel_wide  = ONEHOT_W'(1) << (IDSEL_BASE + 32'(dev));
   assign full_addr = sel_wide
                    | (ONEHOT_W'(func) << FUNC_LSB)
                    | (ONEHOT_W'(off) & ~ONEHOT_W'(BYTES - 1));

   assign out_of_window = |full_addr[ONEHOT_W-1:WIN_BITS];
   assign dev_high      = 32'(dev) > 32'(MAX_DEV);
   assign addr          = full_addr[ADDR_W-1:0];

   if (HOST_FILTER) begin : g_host_filter
      assign host_hit = !is_local && (32'(dev) == 32'(HOST_SLOT));
   end else begin : g_no_filter
      assign host_hit = 1'b0;
   end

   assign size_legal = $onehot(size) && (32'(size) <= 32'(BYTES));
   assign crosses    = (32'(off[SH_W-1:0]) + 32'(size)) > 32'(BYTES);
   assign base_wide  = ((BYTES+1)'(1) << size) - (BYTES+1)'(1);
   assign shift      = off[SH_W-1:0];
   assign lanes      = base_wide[BYTES-1:0] << shift;

   always_comb begin
      if (!size_legal || crosses)
         status = CFG_INVALID;
      else if (dev_high || out_of_window || host_hit)
         status = CFG_NOT_FOUND;
      else
         status = CFG_OK;
   end

endmodule

// File: rtl/pci_cfg_lanes.sv
// Byte-lane extraction for reads and merge for read-modify-write.
module pci_cfg_lanes #(
   parameter int DATA_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int SH_W  = $clog2(BYTES)
) (
   input  logic [DATA_W-1:0] fetched,
   input  logic [DATA_W-1:0] wdata,
   input  logic [SH_W-1:0]   shift,
   input  logic [BYTES-1:0]  lanes,
   output logic [DATA_W-1:0] rd_value,
   output logic [DATA_W-1:0] merged
);

   if (DATA_W % 8 != 0 || BYTES < 2) begin : g_bad_width
      $error("data width must be a multiple of bytes");
   end

   logic [DATA_W-1:0] rd_shifted;
   logic [DATA_W-1:0] wr_shifted;
   logic [BYTES-1:0]  keep;

   assign rd_shifted = fetched >> (8 * 32'(shift));
   assign wr_shifted = wdata << (8 * 32'(shift));
   assign keep       = lanes >> shift;

   for (genvar b = 0; b < BYTES; b++) begin : g_lane
      assign merged[8*b +: 8]   = lanes[b] ? wr_shifted[8*b +: 8] : fetched[8*b +: 8];
      assign rd_value[8*b +: 8] = keep[b]  ? rd_shifted[8*b +: 8] : 8'h00;
   end

endmodule

// File: rtl/pci_cfg_seq.sv
// Access sequencer: request latch, bus phases, abort handling.
module pci_cfg_seq
   import pci_cfg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   localparam int BYTES = DATA_W / 8,
   localparam int SH_W  = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   input  cfg_status_e       dec_status,
   input  logic [ADDR_W-1:0] dec_addr,
   input  logic [BYTES-1:0]  dec_lanes,
   input  logic [SH_W-1:0]   dec_shift,
   output logic [DATA_W-1:0] lat_wdata,
   output logic [BYTES-1:0]  lat_lanes,
   output logic [SH_W-1:0]   lat_shift,
   output logic [DATA_W-1:0] fetched,
   input  logic [DATA_W-1:0] rd_value,
   input  logic [DATA_W-1:0] merged,
   output logic              done_valid,
   output cfg_status_e       done_status,
   output logic [DATA_W-1:0] done_rdata,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_abort,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              cfg_select,
   output logic              abort_clr
);

   seq_state_e        state;
   logic [ADDR_W-1:0] lat_addr;
   logic              lat_write;
   cfg_status_e       res_status;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= SQ_IDLE;
         lat_addr   <= '0;
         lat_write  <= 1'b0;
         lat_wdata  <= '0;
         lat_lanes  <= '0;
         lat_shift  <= '0;
         fetched    <= '0;
         res_status <= CFG_OK;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (req_valid) begin
                  lat_addr   <= dec_addr;
                  lat_write  <= req_write;
                  lat_wdata  <= req_wdata;
                  lat_lanes  <= dec_lanes;
                  lat_shift  <= dec_shift;
                  res_status <= dec_status;
                  state      <= (dec_status == CFG_OK) ? SQ_PREP : SQ_DONE;
               end
            end
            SQ_PREP: state <= SQ_READ;
            SQ_READ: begin
               if (bus_ack) begin
                  if (bus_abort) begin
                     state <= SQ_ABORT;
                  end else begin
                     fetched <= bus_rdata;
                     state   <= lat_write ? SQ_WRITE : SQ_DONE;
                  end
               end
            end
            SQ_WRITE: begin
               if (bus_ack)
                  state <= bus_abort ? SQ_ABORT : SQ_DONE;
            end
            SQ_ABORT: begin
               res_status <= CFG_NOT_FOUND;
               state      <= SQ_DONE;
            end
            SQ_DONE: state <= SQ_IDLE;
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == SQ_IDLE);
   assign bus_req    = (state == SQ_READ) || (state == SQ_WRITE);
   assign bus_write  = (state == SQ_WRITE);
   assign bus_addr   = lat_addr;
   assign bus_wdata  = (state == SQ_WRITE) ? merged : '0;
   assign abort_clr  = (state == SQ_PREP) || (state == SQ_ABORT);
   assign cfg_select = (state == SQ_PREP) || (state == SQ_READ)
                    || (state == SQ_WRITE) || (state == SQ_ABORT);
   assign done_valid  = (state == SQ_DONE);
   assign done_status = res_status;

   always_comb begin
      if (lat_write)
         done_rdata = '0;
      else if (res_status == CFG_OK)
         done_rdata = rd_value;
      else
         done_rdata = '1;
   end

endmodule

// File: rtl/pci_cfg_engine.sv
module pci_cfg_engine
   import pci_cfg_pkg::*;
#(
   parameter int DEV_W       = 5,
   parameter int FUNC_W      = 3,
   parameter int OFF_W       = 8,
   parameter int SIZE_W      = 3,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 32,
   parameter int IDSEL_BASE  = 13,
   parameter int FUNC_LSB    = 8,
   parameter int MAX_DEV     = 18,
   parameter int WIN_BITS    = 20,
   parameter int HOST_SLOT   = 3,
   parameter bit HOST_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_local,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FUNC_W-1:0] req_func,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [SIZE_W-1:0] req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              done_valid,
   output logic [1:0]        done_status,
   output logic [DATA_W-1:0] done_rdata,
   output logic              bus_req,
   output logic              bus_write,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic              bus_abort,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              cfg_select,
   output logic              abort_clr
);

   localparam int BYTES = DATA_W / 8;
   localparam int SH_W  = $clog2(BYTES);

   cfg_status_e       dec_status;
   cfg_status_e       res_status;
   logic [ADDR_W-1:0] dec_addr;
   logic [BYTES-1:0]  dec_lanes;
   logic [SH_W-1:0]   dec_shift;
   logic [DATA_W-1:0] lat_wdata;
   logic [BYTES-1:0]  lat_lanes;
   logic [SH_W-1:0]   lat_shift;
   logic [DATA_W-1:0] fetched;
   logic [DATA_W-1:0] rd_value;
   logic [DATA_W-1:0] merged;

   pci_cfg_decode #(
      .DEV_W(DEV_W), .FUNC_W(FUNC_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W),
      .ADDR_W(ADDR_W), .BYTES(BYTES), .IDSEL_BASE(IDSEL_BASE),
      .FUNC_LSB(FUNC_LSB), .MAX_DEV(MAX_DEV), .WIN_BITS(WIN_BITS),
      .HOST_SLOT(HOST_SLOT), .HOST_FILTER(HOST_FILTER)
   ) u_decode (
      .dev(req_dev), .func(req_func), .off(req_off), .size(req_size),
      .is_local(req_local), .addr(dec_addr), .status(dec_status),
      .lanes(dec_lanes), .shift(dec_shift)
   );

   pci_cfg_lanes #(.DATA_W(DATA_W)) u_lanes (
      .fetched(fetched), .wdata(lat_wdata), .shift(lat_shift),
      .lanes(lat_lanes), .rd_value(rd_value), .merged(merged)
   );

   pci_cfg_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
      .req_ready(req_ready),
      .dec_status(dec_status), .dec_addr(dec_addr), .dec_lanes(dec_lanes),
      .dec_shift(dec_shift),
      .lat_wdata(lat_wdata), .lat_lanes(lat_lanes), .lat_shift(lat_shift),
      .fetched(fetched), .rd_value(rd_value), .merged(merged),
      .done_valid(done_valid), .done_status(res_status), .done_rdata(done_rdata),
      .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_abort(bus_abort),
      .bus_rdata(bus_rdata), .cfg_select(cfg_select), .abort_clr(abort_clr)
   );

   assign done_status = res_status;

endmodule

// File: rtl/pci_cfg_engine_chk.sv
module pci_cfg_engine_chk #(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 32,
   parameter int IDSEL_BASE = 13,
   parameter int WIN_BITS   = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done_valid,
   input logic              bus_req,
   input logic              bus_write,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              bus_ack,
   input logic              bus_abort,
   input logic              cfg_select,
   input logic              abort_clr
);

   // R9
   bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write)
                              && $stable(bus_wdata));

   // R5
   sel_cover_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> cfg_select);

   // R5
   sel_low_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> !cfg_select);

   // R5
   clear_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_select) |-> abort_clr && !bus_req);

   // R8
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack && bus_abort |=> abort_clr && !bus_req);

   // R9
   ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !bus_req && !cfg_select && !done_valid);

   // R9
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R1
   onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> ($countones(bus_addr[ADDR_W-1:IDSEL_BASE]) == 1)
                  && (bus_addr[1:0] == 2'b00));

   // R2
   window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> bus_addr[ADDR_W-1:WIN_BITS] == '0);

endmodule

bind pci_cfg_engine pci_cfg_engine_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDSEL_BASE(IDSEL_BASE), .WIN_BITS(WIN_BITS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done_valid(done_valid),
   .bus_req(bus_req), .bus_write(bus_write), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_abort(bus_abort),
   .cfg_select(cfg_select), .abort_clr(abort_clr)
);

// File: tb/pci_cfg_engine_bench.sv
module pci_cfg_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic        req_local = 1'b0;
   logic [4:0]  req_dev = '0;
   logic [2:0]  req_func = '0;
   logic [7:0]  req_off = '0;
   logic [2:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic        done_valid;
   logic [1:0]  done_status;
   logic [31:0] done_rdata;
   logic        bus_req;
   logic        bus_write;
   logic [31:0] bus_addr;
   logic [31:0] bus_wdata;
   logic        bus_ack = 1'b0;
   logic        bus_abort = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        cfg_select;
   logic        abort_clr;

   always #10 clk = ~clk;

   pci_cfg_engine u_pci_cfg_engine (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_local(req_local), .req_dev(req_dev),
      .req_func(req_func), .req_off(req_off), .req_size(req_size),
      .req_wdata(req_wdata), .done_valid(done_valid), .done_status(done_status),
      .done_rdata(done_rdata), .bus_req(bus_req), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_abort(bus_abort), .bus_rdata(bus_rdata), .cfg_select(cfg_select),
      .abort_clr(abort_clr)
   );

   // Target model: configuration dwords indexed by {dev, func, dword}
   logic [31:0] mem [0:4095];
   bit          present  [0:31];
   bit          wr_abort [0:31];
   int          resp_lat = 0;
   int          wait_cnt = 0;
   int          rd_ops = 0;
   int          wr_ops = 0;
   int          clr_cnt = 0;
   logic [31:0] last_addr = '0;
   int          n_chk = 0;
   int          n_fail = 0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      int d;
      int idx;
      bit ab;
      bus_ack   = 1'b0;
      bus_abort = 1'b0;
      if (abort_clr) clr_cnt++;
      if (bus_req) begin
         if (wait_cnt >= resp_lat) begin
            d = 31;
            for (int k = 0; k < 19; k++) if (bus_addr[13+k]) d = k;
            idx = (d & 7) * 512 + int'(bus_addr[10:8]) * 64 + int'(bus_addr[7:2]);
            ab = !present[d] || (bus_write && wr_abort[d]);
            bus_ack   = 1'b1;
            bus_abort = ab;
            last_addr = bus_addr;
            if (!bus_write) begin
               rd_ops++;
               bus_rdata = ab ? 32'h1234_5678 : mem[idx];
            end else begin
               wr_ops++;
               if (!ab) mem[idx] = bus_wdata;
            end
            wait_cnt = 0;
         end else begin
            wait_cnt++;
         end
      end else begin
         wait_cnt = 0;
      end
   end

   task automatic transact(input bit wr, input bit loc, input int dev, input int func,
                           input int off, input int size, input logic [31:0] wdata,
                           input int lat);
      longint unsigned a;
      bit invalid, notfound, ab_rd, ab_wr;
      int sh, idx, exp_cyc, cyc, rd0, wr0, clr0, exp_rd_ops, exp_wr_ops, exp_clr;
      logic [31:0] old, mask, exp_rd, exp_new;
      logic [1:0]  exp_st;
      string tag;
      a = (64'd1 << (13 + dev)) | (64'(func) << 8) | 64'(off & ~3);
      invalid  = !(size == 1 || size == 2 || size == 4) || ((off % 4) + size > 4);
      notfound = (dev > 18) || (a >= 64'h10_0000) || (dev == 3 && !loc);
      sh   = off % 4;
      idx  = (invalid || notfound) ? 0 : dev * 512 + func * 64 + off / 4;
      old  = mem[idx];
      mask = (size == 4) ? 32'hFFFF_FFFF : (size == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
      ab_rd = !invalid && !notfound && !present[dev];
      ab_wr = !invalid && !notfound && !ab_rd && wr && wr_abort[dev];
      exp_new = (old & ~(mask << (8 * sh))) | ((wdata & mask) << (8 * sh));
      if (invalid) begin
         tag = "R4"; exp_st = 2'b10; exp_cyc = 1;
         exp_rd_ops = 0; exp_wr_ops = 0; exp_clr = 0;
      end else if (notfound) begin
         tag = (dev == 3) ? "R3" : "R2"; exp_st = 2'b01; exp_cyc = 1;
         exp_rd_ops = 0; exp_wr_ops = 0; exp_clr = 0;
      end else if (ab_rd) begin
         tag = "R8"; exp_st = 2'b01; exp_cyc = 4 + lat;
         exp_rd_ops = 1; exp_wr_ops = 0; exp_clr = 2;
      end else if (ab_wr) begin
         tag = "R8"; exp_st = 2'b01; exp_cyc = 5 + 2 * lat;
         exp_rd_ops = 1; exp_wr_ops = 1; exp_clr = 2;
      end else if (wr) begin
         tag = "R7"; exp_st = 2'b00; exp_cyc = 4 + 2 * lat;
         exp_rd_ops = 1; exp_wr_ops = 1; exp_clr = 1;
      end else begin
         tag = "R6"; exp_st = 2'b00; exp_cyc = 3 + lat;
         exp_rd_ops = 1; exp_wr_ops = 0; exp_clr = 1;
      end
      if (wr) exp_rd = 32'h0;
      else if (exp_st != 2'b00) exp_rd = 32'hFFFF_FFFF;
      else exp_rd = (old >> (8 * sh)) & mask;

      resp_lat = lat;
      @(negedge clk);
      chk("R9 ready when idle", 64'(req_ready), 64'd1);
      rd0 = rd_ops; wr0 = wr_ops; clr0 = clr_cnt;
      req_write = wr; req_local = loc; req_dev = 5'(dev); req_func = 3'(func);
      req_off = 8'(off); req_size = 3'(size); req_wdata = wdata; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1;
      while (done_valid !== 1'b1 && cyc < 200) begin
         if (req_ready !== 1'b0) chk("R9 busy not ready", 64'(req_ready), 64'd0);
         @(negedge clk);
         cyc++;
      end
      chk({tag, " R9 completion cycle"}, 64'(cyc), 64'(exp_cyc));
      chk({tag, " status"}, 64'(done_status), 64'(exp_st));
      chk({tag, " data"}, 64'(done_rdata), 64'(exp_rd));
      chk({tag, " read cycles"}, 64'(rd_ops - rd0), 64'(exp_rd_ops));
      chk({tag, " write cycles"}, 64'(wr_ops - wr0), 64'(exp_wr_ops));
      chk({tag, " R5 abort clears"}, 64'(clr_cnt - clr0), 64'(exp_clr));
      chk("R5 select low at done", 64'(cfg_select), 64'd0);
      if (exp_rd_ops != 0) chk("R1 address", 64'(last_addr), 64'(a[31:0]));
      if (tag == "R7") chk("R7 merged dword", 64'(mem[idx]), 64'(exp_new));
      if (ab_wr) chk("R8 target unchanged", 64'(mem[idx]), 64'(old));
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 4096; i++) mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
      for (int i = 0; i < 32; i++) begin
         present[i]  = (i < 19) && (i != 2);
         wr_abort[i] = (i == 5);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10 reset state
      chk("R10 ready", 64'(req_ready), 64'd1);
      chk("R10 done", 64'(done_valid), 64'd0);
      chk("R10 bus_req", 64'(bus_req), 64'd0);
      chk("R10 select", 64'(cfg_select), 64'd0);
      chk("R10 clear", 64'(abort_clr), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 after release", 64'({req_ready, done_valid, bus_req, cfg_select}), 64'b1000);

      // R6 reads, several sizes, offsets and latencies; R1 address
      transact(0, 0, 0, 0, 8'h00, 4, 32'h0, 0);
      transact(0, 0, 1, 2, 8'h0E, 2, 32'h0, 1);
      transact(0, 0, 4, 7, 8'h3F, 1, 32'h0, 2);
      transact(0, 0, 6, 5, 8'hFD, 1, 32'h0, 3);
      // R7 writes then read back
      transact(1, 0, 0, 1, 8'h11, 1, 32'hFFFF_FF5A, 1);
      transact(0, 0, 0, 1, 8'h10, 4, 32'h0, 0);
      transact(1, 0, 6, 0, 8'h22, 2, 32'hABCD_1234, 0);
      transact(1, 0, 1, 3, 8'h40, 4, 32'hCAFE_F00D, 2);
      transact(0, 0, 6, 0, 8'h20, 4, 32'h0, 1);
      // R2 range and window edges
      transact(0, 0, 20, 0, 8'h00, 4, 32'h0, 0);
      transact(1, 0, 7, 0, 8'h00, 4, 32'h1, 0);
      transact(0, 0, 18, 1, 8'h04, 4, 32'h0, 0);
      // R3 own slot
      transact(0, 0, 3, 0, 8'h00, 4, 32'h0, 0);
      transact(0, 1, 3, 0, 8'h00, 4, 32'h0, 1);
      // R4 illegal sizes and crossings (also with an out-of-range device)
      transact(0, 0, 1, 0, 8'h00, 3, 32'h0, 0);
      transact(0, 0, 1, 0, 8'h01, 4, 32'h0, 0);
      transact(1, 0, 1, 0, 8'h03, 2, 32'h5, 0);
      transact(0, 0, 1, 0, 8'h00, 0, 32'h0, 0);
      transact(0, 0, 25, 0, 8'h02, 4, 32'h0, 0);
      // R8 aborts in both phases
      transact(0, 0, 2, 0, 8'h08, 4, 32'h0, 1);
      transact(1, 0, 2, 0, 8'h08, 1, 32'h77, 0);
      transact(1, 0, 5, 4, 8'h1C, 4, 32'h1111_2222, 2);
      transact(0, 0, 5, 4, 8'h1C, 4, 32'h0, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule